// File: doc/BRIEF.md
# Block DMA Channel with Register Interface

This block is one channel of a memory-mapped DMA controller. Software programs a source address, a destination address, a burst count and a control word through a 32-bit register port. It then sets the master enable in a controller-wide operation register. After that, a device-side engine paces the transfer by raising a request for each burst. Each accepted request moves one 32-byte burst between memory and the device port, and it advances whichever address the control word marks as moving.

The count is held in units of 32-byte bursts, so software writes the byte length shifted right by five. When the last burst is taken, the channel sets a transfer-end bit in its control word and leaves the enable bit set. It then refuses further bursts until software rewrites the control word. The burst addresses presented to the bus are always 32-byte aligned.

Top module: `blk_dma_chan`

## Requirements
- R1: After reset every register reads zero and `burst_go` is low.
- R2: The channel registers are at byte offsets CHAN*0x10 plus 0x0 (source), 0x4 (destination), 0x8 (count) and 0xC (control), and the operation register is at 0x40. Each one reads back what was written. The count register holds only CNT_W bits, and the bits above them read zero. A write to any other offset changes nothing, and reads there return zero.
- R3: `burst_go` is high in the same cycle as `dev_req` only when all of these hold: operation bit 0 is set, control bit 0 is set, control bit 1 is clear, and the count is nonzero. Otherwise no burst is taken and no register changes.
- R4: Control bits 13:12 set the source update and bits 15:14 set the destination update: 00 fixed, 01 plus 32, 10 minus 32, 11 fixed. The update is applied once per burst. 0x12C0 therefore means an incrementing source with a fixed destination, and 0x43C0 means the reverse.
- R5: Each burst decrements the count by exactly one. After N bursts from a start address S with an incrementing source, the source reads S + 32*N and the count reads zero.
- R6: The burst that takes the count from 1 to 0 sets control bit 1 and keeps bit 0, so 0x12C1 reads back as 0x12C3. No further burst is taken until a control write clears bit 1.
- R7: `burst_src` and `burst_dst` present the source and destination registers with their low five bits forced to zero.
- R8: A register write in the same cycle as a burst wins for the written register, while the other registers still take the burst update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| dev_req | input | 1 | Device requests one burst |
| burst_go | output | 1 | Burst accepted this cycle |
| burst_src | output | 32 | Aligned source address of the current burst |
| burst_dst | output | 32 | Aligned destination address of the current burst |

## Verification
The hardest state to reach from the ports is a register write landing in the exact cycle of a burst acceptance. The bench raises `dev_req` and drives a count write on the same falling edge, so both act at one rising edge. It then reads back that the count took the written value while the source still advanced. The end-of-transfer lockout is reached by running a programmed count down to zero under a continuously held request, and then holding the request longer.

// File: rtl/blk_dma_chan.sv
module blk_dma_chan #(
  parameter int CHAN   = 2,
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              dev_req,
  output logic              burst_go,
  output logic [31:0]       burst_src,
  output logic [31:0]       burst_dst
);
  localparam int BURST_BYTES = 32;
  localparam int ALIGN_BITS  = $clog2(BURST_BYTES);
  localparam logic [ADDR_W-1:0] OFF_SRC = ADDR_W'(CHAN * 16);
  localparam logic [ADDR_W-1:0] OFF_DST = ADDR_W'(CHAN * 16 + 4);
  localparam logic [ADDR_W-1:0] OFF_CNT = ADDR_W'(CHAN * 16 + 8);
  localparam logic [ADDR_W-1:0] OFF_CTL = ADDR_W'(CHAN * 16 + 12);
  localparam logic [ADDR_W-1:0] OFF_OP  = ADDR_W'(64);

  logic [31:0]      src_q, dst_q, ctl_q, op_q;
  logic [CNT_W-1:0] cnt_q;

  wire wr_src = reg_wr && (reg_addr == OFF_SRC);
  wire wr_dst = reg_wr && (reg_addr == OFF_DST);
  wire wr_cnt = reg_wr && (reg_addr == OFF_CNT);
  wire wr_ctl = reg_wr && (reg_addr == OFF_CTL);
  wire wr_op  = reg_wr && (reg_addr == OFF_OP);

  wire ready    = op_q[0] && ctl_q[0] && !ctl_q[1] && (cnt_q != '0);
  wire last_one = (cnt_q == CNT_W'(1));

  assign burst_go  = ready && dev_req;
  assign burst_src = {src_q[31:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
  assign burst_dst = {dst_q[31:ALIGN_BITS], {ALIGN_BITS{1'b0}}};

  function automatic logic [31:0] step(input logic [31:0] a, input logic [1:0] m);
    case (m)
      2'b01:   step = a + 32'(BURST_BYTES);
      2'b10:   step = a - 32'(BURST_BYTES);
      default: step = a;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      ctl_q <= '0;
      op_q  <= '0;
    end else begin
      if (wr_src)        src_q <= reg_wdata;
      else if (burst_go) src_q <= step(src_q, ctl_q[13:12]);

      if (wr_dst)        dst_q <= reg_wdata;
      else if (burst_go) dst_q <= step(dst_q, ctl_q[15:14]);

      if (wr_cnt)        cnt_q <= reg_wdata[CNT_W-1:0];
      else if (burst_go) cnt_q <= cnt_q - CNT_W'(1);

      if (wr_ctl)                    ctl_q <= reg_wdata;
      else if (burst_go && last_one) ctl_q <= ctl_q | 32'h2;

      if (wr_op) op_q <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFF_SRC) reg_rdata = src_q;
    if (reg_addr == OFF_DST) reg_rdata = dst_q;
    if (reg_addr == OFF_CNT) reg_rdata = 32'(cnt_q);
    if (reg_addr == OFF_CTL) reg_rdata = ctl_q;
    if (reg_addr == OFF_OP)  reg_rdata = op_q;
  end
endmodule

// File: rtl/blk_dma_chan_chk.sv
module blk_dma_chan_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             burst_go,
  input logic             dev_req,
  input logic [CNT_W-1:0] cnt,
  input logic             chan_en,
  input logic             xfer_end,
  input logic             op_en
);
  a_r6_no_burst_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |-> !burst_go);

  a_r3_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_en || !dev_req) |-> !burst_go);

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_go && !reg_wr) |=> (cnt == $past(cnt) - CNT_W'(1)));

  a_r3_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_go && !reg_wr) |=> $stable(cnt));

  a_r6_end_keeps_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_go && !reg_wr && cnt == CNT_W'(1)) |=> (xfer_end && chan_en));
endmodule

bind blk_dma_chan blk_dma_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .burst_go (burst_go),
  .dev_req  (dev_req),
  .cnt      (cnt_q),
  .chan_en  (ctl_q[0]),
  .xfer_end (ctl_q[1]),
  .op_en    (op_q[0])
);

// File: tb/blk_dma_chan_tb_top.sv
`timescale 1ns/1ps
module blk_dma_chan_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [6:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        dev_req = 0;
  logic        burst_go;
  logic [31:0] burst_src, burst_dst;
  int n_run = 0, n_fail = 0;
  bit reported = 0;

  always #5 clk = ~clk;

  blk_dma_chan dut_i (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_req(dev_req),
    .burst_go(burst_go), .burst_src(burst_src), .burst_dst(burst_dst));

  localparam logic [6:0] A_SRC = 7'h20, A_DST = 7'h24, A_CNT = 7'h28, A_CTL = 7'h2C, A_OP = 7'h40;

  localparam logic [70:0] VEC [0:6] = '{
    {7'h20, 32'hDEADBEEF, 32'hDEADBEEF},
    {7'h24, 32'h12345678, 32'h12345678},
    {7'h28, 32'hFFFFFFFF, 32'h00FFFFFF},
    {7'h2C, 32'h000012C0, 32'h000012C0},
    {7'h40, 32'h00008201, 32'h00008201},
    {7'h30, 32'hAAAAAAAA, 32'h00000000},
    {7'h00, 32'h00000005, 32'h00000000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic expect_reg(input string req, input logic [6:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic setup(input logic [31:0] s, input logic [31:0] d,
                       input logic [31:0] n, input logic [31:0] ctl);
    wr(A_CTL, ctl & ~32'h1);
    wr(A_SRC, s);
    wr(A_DST, d);
    wr(A_CNT, n);
    wr(A_CTL, ctl);
    wr(A_OP, 32'h8201);
  endtask

  // Hold dev_req for n cycles, checking each burst's aligned addresses.
  task automatic bursts(input string req, input int n, input logic [31:0] s0,
                        input int ds, input logic [31:0] d0, input int dd);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      dev_req = 1;
      #1;
      check(req, {31'b0, burst_go}, 32'h1);
      check("R7", burst_src, (s0 + 32'(ds * k)) & 32'hFFFFFFE0);
      check(req, burst_dst, (d0 + 32'(dd * k)) & 32'hFFFFFFE0);
    end
    @(negedge clk);
    dev_req = 0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    expect_reg("R1", A_SRC, 0);
    expect_reg("R1", A_CNT, 0);
    expect_reg("R1", A_CTL, 0);
    expect_reg("R1", A_OP, 0);
    check("R1", {31'b0, burst_go}, 0);

    // R2: register map table
    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][70:64], VEC[i][63:32]);
      expect_reg("R2", VEC[i][70:64], VEC[i][31:0]);
    end
    expect_reg("R2", A_SRC, 32'hDEADBEEF);

    // R5/R6: memory to device, 4 bursts
    setup(32'h8C001000, 32'h0, 4, 32'h12C1);
    expect_reg("R2", A_CTL, 32'h12C1);
    bursts("R5", 4, 32'h8C001000, 32, 0, 0);
    expect_reg("R5", A_SRC, 32'h8C001080);
    expect_reg("R5", A_CNT, 0);
    expect_reg("R6", A_CTL, 32'h12C3);
    expect_reg("R4", A_DST, 0);
    @(negedge clk); dev_req = 1; #1;
    check("R6", {31'b0, burst_go}, 0);
    @(negedge clk); dev_req = 0;
    expect_reg("R6", A_SRC, 32'h8C001080);

    // R6: rewrite clears end flag; channel runs again
    wr(A_CNT, 1);
    wr(A_CTL, 32'h12C1);
    bursts("R6", 1, 32'h8C001080, 32, 0, 0);
    expect_reg("R6", A_CTL, 32'h12C3);

    // R4: device to memory, 2 bursts
    setup(32'h0, 32'h8C002000, 2, 32'h43C1);
    bursts("R4", 2, 0, 0, 32'h8C002000, 32);
    expect_reg("R4", A_DST, 32'h8C002040);
    expect_reg("R4", A_SRC, 0);
    expect_reg("R6", A_CTL, 32'h43C3);

    // R4: decrementing source, mode 10
    setup(32'h100, 32'h0, 1, 32'h22C1);
    bursts("R4", 1, 32'h100, -32, 0, 0);
    expect_reg("R4", A_SRC, 32'hE0);

    // R7: unaligned source presented aligned
    setup(32'h8C00101F, 32'h0, 1, 32'h12C1);
    bursts("R7", 1, 32'h8C00101F, 32, 0, 0);
    expect_reg("R7", A_SRC, 32'h8C00103F);

    // R3: master enable clear blocks bursts
    setup(32'h400, 32'h0, 2, 32'h12C1);
    wr(A_OP, 0);
    @(negedge clk); dev_req = 1; #1;
    check("R3", {31'b0, burst_go}, 0);
    @(negedge clk); dev_req = 0;
    expect_reg("R3", A_CNT, 2);
    expect_reg("R3", A_SRC, 32'h400);
    // R3: channel enable clear blocks bursts
    wr(A_OP, 32'h8201);
    wr(A_CTL, 32'h12C0);
    @(negedge clk); dev_req = 1; #1;
    check("R3", {31'b0, burst_go}, 0);
    @(negedge clk); dev_req = 0;
    expect_reg("R3", A_CNT, 2);
    // R3: zero count blocks bursts
    wr(A_CNT, 0);
    wr(A_CTL, 32'h12C1);
    @(negedge clk); dev_req = 1; #1;
    check("R3", {31'b0, burst_go}, 0);
    @(negedge clk); dev_req = 0;
    expect_reg("R3", A_CTL, 32'h12C1);

    // R8: count write collides with a burst
    setup(32'h1000, 32'h0, 3, 32'h12C1);
    @(negedge clk);
    dev_req = 1; reg_wr = 1; reg_addr = A_CNT; reg_wdata = 9;
    #1 check("R8", {31'b0, burst_go}, 1);
    @(negedge clk);
    dev_req = 0; reg_wr = 0;
    expect_reg("R8", A_CNT, 9);
    expect_reg("R8", A_SRC, 32'h1020);

    report();
    $finish;
  end
endmodule